// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

This block is the register side of a general-purpose I/O controller on an APB bus. It holds up to four ports of up to 32 lines each. Every port has an output value register and a direction register that software can write and read back. Each port also has a read-only input view of its pins, taken through a two-stage synchronizer. The stored registers drive the per-pin output value and output enable straight to the pad ring.

The interrupt and debounce registers live in a separate block. This bank only decodes their offsets and hands that block a select code and a hit strobe. It then returns the read data that block supplies. A strap input picks one of two offset layouts for that interrupt window. All other offsets are the same in both layouts.

Ports and width are parameters. Offsets that belong to absent ports, or that fall outside the map, read as zero and ignore writes. The bus never stalls and never signals an error.

Top module: `gpio_port_bank`

## Requirements
- R1: The output value register of port p (p counting from 0) sits at byte offset 12*p. A read returns its low PORT_WIDTH bits, and all bits above them read as zero.
- R2: The direction register of port p sits at byte offset 12*p+4. Its value drives that port's slice of pin_oe, where 1 drives the pin and 0 leaves it as an input.
- R3: The output value register of port p drives that port's slice of pin_out, starting with the clock edge that completes the write.
- R4: The input view of port p sits at byte offset 0x50+4*p. A change on pin_in becomes readable after exactly two rising clock edges.
- R5: Writes to the input views change no register and no pin output.
- R6: Reads return zero at unmapped offsets and at offsets of ports beyond NUM_PORTS. Writes there have no effect.
- R7: pready is always 1 and pslverr is always 0.
- R8: Reset clears every output value and direction register, so all pins start as inputs with pin_out at zero.
- R9: With layout_alt=0, the interrupt window maps these offsets to these irq_sel codes: 0x30 to 0 (enable), 0x34 to 1 (mask), 0x38 to 2 (type), 0x3C to 3 (polarity), 0x40 to 4 (status), 0x48 to 5 (debounce) and 0x4C to 6 (end-of-interrupt). Offset 0x44 is unmapped.
- R10: With layout_alt=1, the codes map as follows: 0x30 to 0, 0x34 to 2, 0x38 to 3, 0x3C to 4, 0x40 to 6, 0x44 to 1 and 0x48 to 5. Offset 0x4C is unmapped.
- R11: irq_hit is 1 only while psel is 1 and the address falls in the active interrupt window. While irq_hit is 1, prdata equals irq_rdata.
- R12: A register is written only in the access phase (psel, penable and pwrite all 1). A setup cycle alone writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always low |
| layout_alt | input | 1 | Strap selecting the alternate interrupt layout |
| irq_rdata | input | 32 | Read data from the interrupt block |
| irq_hit | output | 1 | Current address falls in the interrupt window |
| irq_sel | output | 3 | Which interrupt register is addressed |
| pin_in | input | NUM_PORTS*PORT_WIDTH | Raw pin levels |
| pin_out | output | NUM_PORTS*PORT_WIDTH | Pin output values |
| pin_oe | output | NUM_PORTS*PORT_WIDTH | Pin output enables |

## Verification
The bench builds the bank with three ports of 20 lines. Port D's offsets therefore fall into the absent-port case, and writes of all-ones show that register bits above line 19 read back as zero. Ports B and C exercise the 12-byte stride of the stored registers and the 4-byte stride of the input views. Both strap settings are driven, so each interrupt offset that moves between layouts is seen both mapped and unmapped.

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int NUM_PORTS  = 4,
  parameter int PORT_WIDTH = 32,
  parameter int ADDR_W     = 7
) (
  input  logic                            pclk,
  input  logic                            presetn,
  input  logic                            psel,
  input  logic                            penable,
  input  logic                            pwrite,
  input  logic [ADDR_W-1:0]               paddr,
  input  logic [31:0]                     pwdata,
  output logic [31:0]                     prdata,
  output logic                            pready,
  output logic                            pslverr,
  input  logic                            layout_alt,
  input  logic [31:0]                     irq_rdata,
  output logic                            irq_hit,
  output logic [2:0]                      irq_sel,
  input  logic [NUM_PORTS*PORT_WIDTH-1:0] pin_in,
  output logic [NUM_PORTS*PORT_WIDTH-1:0] pin_out,
  output logic [NUM_PORTS*PORT_WIDTH-1:0] pin_oe
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int EXT_BASE = 20;
  localparam logic [2:0] SEL_EN = 3'd0, SEL_MASK = 3'd1, SEL_TYPE = 3'd2,
                         SEL_POL = 3'd3, SEL_STAT = 3'd4, SEL_DEB = 3'd5,
                         SEL_EOI = 3'd6;

  logic [PORT_WIDTH-1:0] dout_q  [NUM_PORTS];
  logic [PORT_WIDTH-1:0] dir_q   [NUM_PORTS];
  logic [PORT_WIDTH-1:0] sync1_q [NUM_PORTS];
  logic [PORT_WIDTH-1:0] sync2_q [NUM_PORTS];

  logic [WORD_W-1:0] word;
  logic              wr_en;
  logic [31:0]       local_rd;
  logic              irq_dec;
  logic              unused_bits;

  assign word        = paddr[ADDR_W-1:2];
  assign wr_en       = psel & penable & pwrite;
  assign pready      = 1'b1;
  assign pslverr     = 1'b0;
  assign unused_bits = ^{paddr[1:0], pwdata};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        dout_q[p]  <= '0;
        dir_q[p]   <= '0;
        sync1_q[p] <= '0;
        sync2_q[p] <= '0;
      end else begin
        if (wr_en && word == WORD_W'(3*p))     dout_q[p] <= pwdata[PORT_WIDTH-1:0];
        if (wr_en && word == WORD_W'(3*p + 1)) dir_q[p]  <= pwdata[PORT_WIDTH-1:0];
        sync1_q[p] <= pin_in[p*PORT_WIDTH +: PORT_WIDTH];
        sync2_q[p] <= sync1_q[p];
      end
    end
    assign pin_out[p*PORT_WIDTH +: PORT_WIDTH] = dout_q[p];
    assign pin_oe[p*PORT_WIDTH +: PORT_WIDTH]  = dir_q[p];
  end

  always_comb begin
    local_rd = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (word == WORD_W'(3*p))          local_rd[PORT_WIDTH-1:0] = dout_q[p];
      if (word == WORD_W'(3*p + 1))      local_rd[PORT_WIDTH-1:0] = dir_q[p];
      if (word == WORD_W'(EXT_BASE + p)) local_rd[PORT_WIDTH-1:0] = sync2_q[p];
    end
  end

  always_comb begin
    irq_dec = 1'b1;
    irq_sel = SEL_EN;
    if (!layout_alt) begin
      case (word)
        WORD_W'(12): irq_sel = SEL_EN;
        WORD_W'(13): irq_sel = SEL_MASK;
        WORD_W'(14): irq_sel = SEL_TYPE;
        WORD_W'(15): irq_sel = SEL_POL;
        WORD_W'(16): irq_sel = SEL_STAT;
        WORD_W'(18): irq_sel = SEL_DEB;
        WORD_W'(19): irq_sel = SEL_EOI;
        default:     irq_dec = 1'b0;
      endcase
    end else begin
      case (word)
        WORD_W'(12): irq_sel = SEL_EN;
        WORD_W'(13): irq_sel = SEL_TYPE;
        WORD_W'(14): irq_sel = SEL_POL;
        WORD_W'(15): irq_sel = SEL_STAT;
        WORD_W'(16): irq_sel = SEL_EOI;
        WORD_W'(17): irq_sel = SEL_MASK;
        WORD_W'(18): irq_sel = SEL_DEB;
        default:     irq_dec = 1'b0;
      endcase
    end
  end

  assign irq_hit = psel & irq_dec;
  assign prdata  = irq_hit ? irq_rdata : local_rd;
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
  parameter int NUM_PORTS  = 4,
  parameter int PORT_WIDTH = 32,
  parameter int ADDR_W     = 7
) (
  input logic                            pclk,
  input logic                            presetn,
  input logic                            psel,
  input logic                            penable,
  input logic                            pwrite,
  input logic [ADDR_W-1:0]               paddr,
  input logic [31:0]                     pwdata,
  input logic [31:0]                     prdata,
  input logic                            pready,
  input logic                            pslverr,
  input logic                            irq_hit,
  input logic [NUM_PORTS*PORT_WIDTH-1:0] pin_in,
  input logic [NUM_PORTS*PORT_WIDTH-1:0] pin_out,
  input logic [NUM_PORTS*PORT_WIDTH-1:0] pin_oe
);
  logic [1:0] up_cnt;
  logic       wr;

  assign wr = psel & penable & pwrite;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;

  assert_bus_ok_R7: assert property (@(posedge pclk) disable iff (!presetn)
    pready && !pslverr);

  assert_dir_drives_oe_R2: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && paddr == ADDR_W'(4)) |=> pin_oe[PORT_WIDTH-1:0] == $past(pwdata[PORT_WIDTH-1:0]));

  assert_data_drives_out_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && paddr == ADDR_W'(0)) |=> pin_out[PORT_WIDTH-1:0] == $past(pwdata[PORT_WIDTH-1:0]));

  assert_input_write_ignored_R5: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && paddr == ADDR_W'(8'h50)) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_high_offsets_zero_R6: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr >= ADDR_W'(8'h60)) |-> prdata == 32'd0);

  assert_hit_needs_select_R11: assert property (@(posedge pclk) disable iff (!presetn)
    !psel |-> !irq_hit);

  assert_sync_latency_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (up_cnt >= 2'd2 && psel && !pwrite && paddr == ADDR_W'(8'h50))
      |-> prdata[PORT_WIDTH-1:0] == $past(pin_in[PORT_WIDTH-1:0], 2));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .PORT_WIDTH(PORT_WIDTH), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_gpio_port_bank.sv
module test_gpio_port_bank;
  localparam int NP = 3;
  localparam int PW = 20;
  localparam int AW = 7;
  localparam logic [31:0] IRQ_DATA = 32'hA5A5_0F0F;

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 7'h00, 32'hFFFF_1234, 4'd1},  // R1 port A value, wide data
    '{1'b0, 7'h00, 32'h000F_1234, 4'd1},  // R1 upper bits read zero
    '{1'b1, 7'h10, 32'h000A_BCDE, 4'd2},  // R2 port B direction
    '{1'b0, 7'h10, 32'h000A_BCDE, 4'd2},  // R2
    '{1'b1, 7'h18, 32'h0001_2345, 4'd1},  // R1 port C value
    '{1'b0, 7'h18, 32'h0001_2345, 4'd1},  // R1
    '{1'b1, 7'h24, 32'hFFFF_FFFF, 4'd6},  // R6 absent port D
    '{1'b0, 7'h24, 32'h0000_0000, 4'd6},  // R6
    '{1'b0, 7'h08, 32'h0000_0000, 4'd6},  // R6 hole in map
    '{1'b1, 7'h50, 32'hFFFF_FFFF, 4'd5},  // R5 write to input view
    '{1'b0, 7'h50, 32'h0000_0000, 4'd5},  // R5
    '{1'b0, 7'h00, 32'h000F_1234, 4'd5},  // R5 stored value untouched
    '{1'b0, 7'h7C, 32'h0000_0000, 4'd6},  // R6 top of map
    '{1'b0, 7'h0C, 32'h0000_0000, 4'd8}   // R8 never-written register
  };

  logic            pclk = 1'b0;
  logic            presetn = 1'b0;
  logic            psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0]   paddr = '0;
  logic [31:0]     pwdata = '0;
  logic [31:0]     prdata;
  logic            pready, pslverr;
  logic            layout_alt = 1'b0;
  logic            irq_hit;
  logic [2:0]      irq_sel;
  logic [NP*PW-1:0] pin_in = '0;
  logic [NP*PW-1:0] pin_out, pin_oe;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 pclk = ~pclk;

  gpio_port_bank #(.NUM_PORTS(NP), .PORT_WIDTH(PW), .ADDR_W(AW)) i_gpio_port_bank (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .layout_alt(layout_alt), .irq_rdata(IRQ_DATA), .irq_hit(irq_hit), .irq_sel(irq_sel),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic probe(input logic [AW-1:0] a);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge pclk);
    #1;
    check("R8 pin_oe after reset", 64'(pin_oe), 64'd0);
    check("R8 pin_out after reset", 64'(pin_out), 64'd0);
    check("R7 bus flags", {62'd0, pready, pslverr}, 64'd2);
    presetn = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) apb_write(VECS[i].addr, VECS[i].data);
      else begin
        apb_read(VECS[i].addr, rd);
        check($sformatf("R%0d table entry %0d", VECS[i].req, i), 64'(rd), 64'(VECS[i].data));
      end
    end

    #1;
    check("R3 port A pins", 64'(pin_out[PW-1:0]), 64'h000F_1234);
    check("R3 port C pins", 64'(pin_out[2*PW +: PW]), 64'h0001_2345);
    check("R2 port B enables", 64'(pin_oe[PW +: PW]), 64'h000A_BCDE);
    check("R2 port A enables", 64'(pin_oe[PW-1:0]), 64'd0);

    probe(7'h54);
    pin_in[PW +: PW] = 20'h5A5A5;
    #1 check("R4 before any edge", 64'(prdata), 64'd0);
    @(negedge pclk); #1 check("R4 after one edge", 64'(prdata), 64'd0);
    @(negedge pclk); #1 check("R4 after two edges", 64'(prdata), 64'h5_A5A5);
    psel = 1'b0;
    pin_in[2*PW +: PW] = 20'hC3C3C;
    repeat (3) @(negedge pclk);
    apb_read(7'h58, rd);
    check("R4 port C input view", 64'(rd), 64'hC_3C3C);

    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 7'h00; pwdata = 32'h0;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    apb_read(7'h00, rd);
    check("R12 setup-only write", 64'(rd), 64'h000F_1234);
    check("R12 pins unchanged", 64'(pin_out[PW-1:0]), 64'h000F_1234);

    layout_alt = 1'b0;
    probe(7'h34); check("R9 0x34 select", {60'd0, irq_hit, irq_sel}, {60'd0, 1'b1, 3'd1});
    probe(7'h4C); check("R9 0x4C select", {60'd0, irq_hit, irq_sel}, {60'd0, 1'b1, 3'd6});
    probe(7'h48); check("R9 0x48 select", {60'd0, irq_hit, irq_sel}, {60'd0, 1'b1, 3'd5});
    probe(7'h44); check("R9 0x44 unmapped", {63'd0, irq_hit}, 64'd0);
    check("R9 0x44 reads zero", 64'(prdata), 64'd0);
    probe(7'h30); check("R11 irq data muxed", 64'(prdata), 64'(IRQ_DATA));

    layout_alt = 1'b1;
    probe(7'h44); check("R10 0x44 select", {60'd0, irq_hit, irq_sel}, {60'd0, 1'b1, 3'd1});
    probe(7'h34); check("R10 0x34 select", {60'd0, irq_hit, irq_sel}, {60'd0, 1'b1, 3'd2});
    probe(7'h40); check("R10 0x40 select", {60'd0, irq_hit, irq_sel}, {60'd0, 1'b1, 3'd6});
    probe(7'h4C); check("R10 0x4C unmapped", {63'd0, irq_hit}, 64'd0);
    check("R10 0x4C reads zero", 64'(prdata), 64'd0);
    @(negedge pclk);
    psel = 1'b0; paddr = 7'h34;
    #1 check("R11 no hit without select", {63'd0, irq_hit}, 64'd0);

    @(negedge pclk);
    presetn = 1'b0;
    #1 check("R8 async clear pins", 64'(pin_out), 64'd0);
    @(negedge pclk);
    presetn = 1'b1;
    apb_read(7'h10, rd);
    check("R8 direction cleared", 64'(rd), 64'd0);
    check("R7 bus flags at end", {62'd0, pready, pslverr}, 64'd2);

    finish_run();
  end
endmodule